// File: doc/BRIEF.md
# Exception Control Coprocessor

This block is the system-control coprocessor of a small 32-bit in-order core. It holds three architectural registers: status, cause and the exception return address (EPC). Each cycle the pipeline presents one synchronous exception request and a level or pulsed external interrupt request. It also presents at most one coprocessor instruction, together with the value of that instruction's general register. The block answers in the same cycle. It raises a redirect with the target PC, a general-register write for move-from, and a pulse that kills the load-linked reservation. In the cycle `redirect` is high, the pipeline flushes the instruction under consideration and every younger one.

An exception taken while the exception-level flag is clear records the cause code and the return address. An exception taken while the flag is already set keeps the old return address, writes zero to cause, and still vectors. The vector is base plus 0x180. The base is 0xBFC00200 while the bootstrap bit is set and 0x80000000 otherwise.

Masked interrupts are held by a two-state machine. `IRQ_IDLE` has nothing held. It moves to `IRQ_WAIT` when a request arrives that cannot be taken in that cycle. `IRQ_WAIT` holds exactly one request and retries it every cycle. It returns to `IRQ_IDLE` in the cycle the interrupt is taken. A request that is taken on arrival keeps the machine in `IRQ_IDLE`.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, status reads 0x00400004 (bootstrap bit 22 and error-level bit 2 set, interrupt enable bit 0 clear), cause and EPC read 0, `irq_pending` is 0 and `redirect` is 0.
- R2: An exception taken with exception level (status bit 1) clear sets cause to the 5-bit code in bits 6:2 and the delay flag in bit 31, with all other bits 0. EPC becomes `cur_pc`, or `cur_pc` minus 4 when `cur_in_delay` is 1.
- R3: An exception taken with exception level already set leaves EPC unchanged and writes cause to 0.
- R4: Every taken exception or interrupt asserts `redirect` in the same cycle, with `redirect_pc` 0xBFC00380 when status bit 22 is 1 and 0x80000180 when it is 0. It sets status bit 1 at the next edge.
- R5: `llbit_clr` is high in exactly the cycles in which an exception or interrupt is taken, and it stays low for exception return.
- R6: An interrupt is taken only while status bit 0 is 1. It is recorded with code 0, and it is taken in its arrival cycle if enabled.
- R7: A masked request is held (`irq_pending` = 1) and retried every cycle. Further requests while it is held add nothing, and taking it clears the hold, so one request gives one redirect.
- R8: Priority is exception, then interrupt, then coprocessor instruction. A losing interrupt is held, and a losing coprocessor instruction has no effect on status or on the register write.
- R9: A move-from is recognised when instruction bits 25:21 are 0x00 and bits 10:0 are 0. It writes general register bits 20:16 with status when register field bits 15:11 is 12, and 0xDEADC0DE for any other register number.
- R10: A move-to is recognised when bits 25:21 are 0x04 and bits 10:0 are 0. Status takes `gpr_rdata` at the next edge when bits 15:11 are 12, and any other register number leaves status unchanged.
- R11: Exception return is bits 25:21 = 0x10 with bits 5:0 = 0x18. It redirects to EPC and clears status bit 2 if that bit is set, otherwise it clears status bit 1.
- R12: An instruction that matches none of the three encodings has no effect. This includes a move with any of bits 10:0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Synchronous exception request this cycle |
| exc_code | input | 5 | Exception code |
| cur_pc | input | 32 | PC of the instruction being considered |
| cur_in_delay | input | 1 | That instruction sits in a branch delay slot |
| irq_req | input | 1 | External interrupt request |
| cop_valid | input | 1 | A coprocessor-0 instruction is presented |
| cop_insn | input | 32 | Instruction word |
| gpr_rdata | input | 32 | Value of the instruction's general register |
| redirect | output | 1 | Flush and fetch from `redirect_pc` |
| redirect_pc | output | 32 | Vector or return address |
| gpr_we | output | 1 | Move-from register write enable |
| gpr_waddr | output | 5 | Move-from destination register |
| gpr_wdata | output | 32 | Move-from data |
| llbit_clr | output | 1 | Clear the load-linked reservation |
| irq_pending | output | 1 | A masked interrupt is held |
| status | output | 32 | Status register |
| cause | output | 32 | Cause register |
| epc | output | 32 | Exception return address |

## Verification
Three functions can fall in one cycle. A synchronous exception, a fresh interrupt request and a move-to that writes status are driven together. The bench expects the exception's vector and cause, status with only the exception-level bit added, and the interrupt held. In the following cycle it expects the held interrupt to be taken as a nested exception, with cause zero and EPC kept. The second collision is a move-to that sets the enable while an interrupt is held. The write must land first, and the redirect must come exactly one cycle later, once.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

    localparam int SR_IE    = 0;
    localparam int SR_EXL   = 1;
    localparam int SR_ERL   = 2;
    localparam int SR_BEV   = 22;
    localparam int CAUSE_BD = 31;

    localparam logic [4:0] FMT_MFROM = 5'h00;
    localparam logic [4:0] FMT_MTO   = 5'h04;
    localparam logic [4:0] FMT_CTRL  = 5'h10;
    localparam logic [5:0] FN_XRET   = 6'h18;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_WAIT = 1'b1
    } irq_st_t;

    typedef struct packed {
        logic       mf;
        logic       mt;
        logic       xret;
        logic [4:0] rt;
        logic [4:0] rd;
    } cop_op_t;

endpackage

// File: rtl/cop_decode.sv
module cop_decode
    import exc_ctrl_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] insn,
    output cop_op_t     op
);

    logic low_clear;

    always_comb begin
        low_clear = (insn[10:0] == 11'd0);
        op.rt     = insn[20:16];
        op.rd     = insn[15:11];
        op.mf     = valid && (insn[25:21] == FMT_MFROM) && low_clear;
        op.mt     = valid && (insn[25:21] == FMT_MTO) && low_clear;
        op.xret   = valid && (insn[25:21] == FMT_CTRL) && (insn[5:0] == FN_XRET);
    end

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import exc_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic irq_en,
    input  logic blocked,
    output logic take,
    output logic pending
);

    irq_st_t st;
    irq_st_t st_nx;
    logic    want;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= IRQ_IDLE;
        else
            st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            IRQ_IDLE: if (irq_req && !(irq_en && !blocked)) st_nx = IRQ_WAIT;
            IRQ_WAIT: if (irq_en && !blocked)               st_nx = IRQ_IDLE;
        endcase
    end

    always_comb begin
        want    = 1'b0;
        pending = 1'b0;
        unique case (st)
            IRQ_IDLE: want = irq_req;
            IRQ_WAIT: begin
                want    = 1'b1;
                pending = 1'b1;
            end
        endcase
        take = want && irq_en && !blocked;
    end

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_ctrl_pkg::*;
#(
    parameter int              XW         = 32,
    parameter int              CODE_W     = 5,
    parameter int              STATUS_REG = 12,
    parameter int              DS_BYTES   = 4,
    parameter logic [XW-1:0]   BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [XW-1:0]   NORM_BASE  = 32'h8000_0000,
    parameter logic [XW-1:0]   VEC_OFS    = 32'h0000_0180,
    parameter logic [XW-1:0]   MARKER     = 32'hDEAD_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XW-1:0]     cur_pc,
    input  logic              cur_in_delay,
    input  logic              irq_req,
    input  logic              cop_valid,
    input  logic [31:0]       cop_insn,
    input  logic [XW-1:0]     gpr_rdata,
    output logic              redirect,
    output logic [XW-1:0]     redirect_pc,
    output logic              gpr_we,
    output logic [4:0]        gpr_waddr,
    output logic [XW-1:0]     gpr_wdata,
    output logic              llbit_clr,
    output logic              irq_pending,
    output logic [XW-1:0]     status,
    output logic [XW-1:0]     cause,
    output logic [XW-1:0]     epc
);

    localparam logic [XW-1:0] RST_STATUS = (XW'(1) << SR_BEV) | (XW'(1) << SR_ERL);
    localparam logic [4:0]    SR_IDX     = 5'(STATUS_REG);

    cop_op_t           op;
    logic              irq_take;
    logic              trap;
    logic [CODE_W-1:0] trap_code;
    logic [XW-1:0]     vec_addr;
    logic [XW-1:0]     cause_new;
    logic [XW-1:0]     epc_new;
    logic              do_xret;
    logic              do_mf;
    logic              do_mt;
    logic              sr_hit;
    logic [XW-1:0]     sr_q;
    logic [XW-1:0]     cause_q;
    logic [XW-1:0]     epc_q;

    cop_decode u_dec (
        .valid (cop_valid),
        .insn  (cop_insn),
        .op    (op)
    );

    irq_gate u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .irq_en  (sr_q[SR_IE]),
        .blocked (exc_valid),
        .take    (irq_take),
        .pending (irq_pending)
    );

    // Arbitration: exception, then interrupt, then coprocessor instruction.
    always_comb begin
        trap      = exc_valid || irq_take;
        trap_code = exc_valid ? exc_code : '0;
        vec_addr  = (sr_q[SR_BEV] ? BOOT_BASE : NORM_BASE) + VEC_OFS;
        do_xret   = op.xret && !trap;
        do_mf     = op.mf && !trap;
        do_mt     = op.mt && !trap;
        sr_hit    = (op.rd == SR_IDX);

        cause_new                = '0;
        cause_new[CODE_W+1:2]    = trap_code;
        cause_new[CAUSE_BD]      = cur_in_delay;
        epc_new                  = cur_in_delay ? (cur_pc - XW'(DS_BYTES)) : cur_pc;
    end

    always_comb begin
        redirect    = trap || do_xret;
        redirect_pc = trap ? vec_addr : epc_q;
        gpr_we      = do_mf;
        gpr_waddr   = op.rt;
        gpr_wdata   = sr_hit ? sr_q : MARKER;
        llbit_clr   = trap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= RST_STATUS;
            cause_q <= '0;
            epc_q   <= '0;
        end else if (trap) begin
            if (!sr_q[SR_EXL]) begin
                cause_q <= cause_new;
                epc_q   <= epc_new;
            end else begin
                cause_q <= '0;
            end
            sr_q[SR_EXL] <= 1'b1;
        end else if (do_xret) begin
            if (sr_q[SR_ERL])
                sr_q[SR_ERL] <= 1'b0;
            else
                sr_q[SR_EXL] <= 1'b0;
        end else if (do_mt && sr_hit) begin
            sr_q <= gpr_rdata;
        end
    end

    assign status = sr_q;
    assign cause  = cause_q;
    assign epc    = epc_q;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_valid,
    input logic [31:0] cur_pc,
    input logic        cur_in_delay,
    input logic        redirect,
    input logic [31:0] redirect_pc,
    input logic        gpr_we,
    input logic        llbit_clr,
    input logic        irq_pending,
    input logic [31:0] status,
    input logic [31:0] cause,
    input logic [31:0] epc
);

    a_r2_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && !status[1] |=>
            epc == ($past(cur_in_delay) ? $past(cur_pc) - 32'd4 : $past(cur_pc)));

    a_r3_nested_keeps_epc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && status[1] |=> (cause == 32'd0) && $stable(epc));

    a_r4_trap_sets_exl: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> status[1]);

    a_r5_llbit_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> llbit_clr && redirect);

    a_r6_masked_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
        redirect && !exc_valid && !status[0] |-> redirect_pc == epc);

    a_r7_hold_while_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending && !status[0] |=> irq_pending);

    a_r8_flush_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !gpr_we);

endmodule

bind exc_ctrl_unit exc_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_valid    (exc_valid),
    .cur_pc       (cur_pc),
    .cur_in_delay (cur_in_delay),
    .redirect     (redirect),
    .redirect_pc  (redirect_pc),
    .gpr_we       (gpr_we),
    .llbit_clr    (llbit_clr),
    .irq_pending  (irq_pending),
    .status       (status),
    .cause        (cause),
    .epc          (epc)
);

// File: tb/sim_exc_ctrl_unit.sv
`timescale 1ns/1ps
module sim_exc_ctrl_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_valid;
    logic [4:0]  exc_code;
    logic [31:0] cur_pc;
    logic        cur_in_delay;
    logic        irq_req;
    logic        cop_valid;
    logic [31:0] cop_insn;
    logic [31:0] gpr_rdata;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic        gpr_we;
    logic [4:0]  gpr_waddr;
    logic [31:0] gpr_wdata;
    logic        llbit_clr;
    logic        irq_pending;
    logic [31:0] status;
    logic [31:0] cause;
    logic [31:0] epc;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    exc_ctrl_unit u0 (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .cur_pc(cur_pc), .cur_in_delay(cur_in_delay), .irq_req(irq_req),
        .cop_valid(cop_valid), .cop_insn(cop_insn), .gpr_rdata(gpr_rdata),
        .redirect(redirect), .redirect_pc(redirect_pc), .gpr_we(gpr_we),
        .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata), .llbit_clr(llbit_clr),
        .irq_pending(irq_pending), .status(status), .cause(cause), .epc(epc)
    );

    function automatic logic [31:0] enc_mf(input logic [4:0] rt, input logic [4:0] rd);
        return {6'b010000, 5'h00, rt, rd, 11'd0};
    endfunction

    function automatic logic [31:0] enc_mt(input logic [4:0] rt, input logic [4:0] rd);
        return {6'b010000, 5'h04, rt, rd, 11'd0};
    endfunction

    localparam logic [31:0] ENC_XRET = 32'h4200_0018;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        exc_valid = 0; exc_code = 0; cur_pc = 0; cur_in_delay = 0;
        irq_req = 0; cop_valid = 0; cop_insn = 0; gpr_rdata = 0;
    endtask

    task automatic edge_after();
        @(posedge clk); #1; idle();
    endtask

    task automatic wr_status(input logic [31:0] v);
        @(negedge clk);
        cop_valid = 1; cop_insn = enc_mt(5'd3, 5'd12); gpr_rdata = v;
        edge_after();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        // R1 reset state
        chk("R1 status", status, 32'h0040_0004);
        chk("R1 cause", cause, 0);
        chk("R1 epc", epc, 0);
        chk("R1 pending", 32'(irq_pending), 0);
        chk("R1 redirect", 32'(redirect), 0);

        // R9 move-from sweep over every register number
        for (int rd = 0; rd < 32; rd++) begin
            @(negedge clk);
            cop_valid = 1; cop_insn = enc_mf(5'(31 - rd), 5'(rd)); #1;
            chk("R9 we", 32'(gpr_we), 1);
            chk("R9 waddr", 32'(gpr_waddr), 32'(31 - rd));
            chk("R9 data", gpr_wdata, (rd == 12) ? 32'h0040_0004 : 32'hDEAD_C0DE);
            edge_after();
        end

        // R12 malformed encodings
        for (int b = 0; b < 11; b++) begin
            @(negedge clk);
            cop_valid = 1; cop_insn = enc_mf(5'd1, 5'd12) | (32'd1 << b); #1;
            chk("R12 mf low bits", 32'(gpr_we), 0);
            edge_after();
            @(negedge clk);
            cop_valid = 1; cop_insn = enc_mt(5'd1, 5'd12) | (32'd1 << b); gpr_rdata = 32'hFFFF_FFFF;
            edge_after();
            chk("R12 mt low bits", status, 32'h0040_0004);
        end
        @(negedge clk);
        cop_valid = 1; cop_insn = {6'b010000, 5'h01, 5'd2, 5'd12, 11'd0}; #1;
        chk("R12 other fmt", 32'(gpr_we), 0);
        chk("R12 other fmt redirect", 32'(redirect), 0);
        edge_after();

        // R10 move-to: ignored for non-status numbers
        for (int rd = 0; rd < 32; rd++) begin
            if (rd != 12) begin
                @(negedge clk);
                cop_valid = 1; cop_insn = enc_mt(5'd4, 5'(rd)); gpr_rdata = 32'hFFFF_FFFF;
                edge_after();
                chk("R10 ignored", status, 32'h0040_0004);
            end
        end
        wr_status(32'h0040_0000);
        chk("R10 status write", status, 32'h0040_0000);

        // R2 / R4 / R5 sweep over codes and delay-slot flag
        for (int c = 1; c < 32; c++) begin
            for (int d = 0; d < 2; d++) begin
                logic [31:0] pcv;
                pcv = 32'h1000 + 32'(c) * 16;
                wr_status(32'h0040_0000);
                @(negedge clk);
                exc_valid = 1; exc_code = 5'(c); cur_pc = pcv; cur_in_delay = d[0]; #1;
                chk("R4 redirect", 32'(redirect), 1);
                chk("R4 boot vector", redirect_pc, 32'hBFC0_0380);
                chk("R5 llbit", 32'(llbit_clr), 1);
                edge_after();
                chk("R2 cause", cause, (32'(d) << 31) | (32'(c) << 2));
                chk("R2 epc", epc, pcv - 32'(d) * 4);
                chk("R4 exl set", status, 32'h0040_0002);
            end
        end

        // R3 nested exception
        @(negedge clk);
        exc_valid = 1; exc_code = 5'd5; cur_pc = 32'h5554; #1;
        chk("R3 vector", redirect_pc, 32'hBFC0_0380);
        edge_after();
        chk("R3 cause zero", cause, 0);
        chk("R3 epc kept", epc, 32'h11EC);

        // R4 normal vector base
        wr_status(32'h0);
        @(negedge clk);
        exc_valid = 1; exc_code = 5'd7; cur_pc = 32'h7000; #1;
        chk("R4 normal vector", redirect_pc, 32'h8000_0180);
        edge_after();
        chk("R2 cause code7", cause, 32'h1C);
        chk("R2 epc 7000", epc, 32'h7000);
        chk("R4 exl", status, 32'h2);

        // R11 exception return, both flag cases; R5 stays low
        @(negedge clk);
        cop_valid = 1; cop_insn = ENC_XRET; #1;
        chk("R11 redirect", 32'(redirect), 1);
        chk("R11 target", redirect_pc, 32'h7000);
        chk("R5 no llbit on return", 32'(llbit_clr), 0);
        edge_after();
        chk("R11 exl cleared", status, 32'h0);
        wr_status(32'h6);
        @(negedge clk);
        cop_valid = 1; cop_insn = ENC_XRET; #1;
        chk("R11 target erl", redirect_pc, 32'h7000);
        edge_after();
        chk("R11 erl cleared first", status, 32'h2);

        // R6 / R7 masked interrupt held, then released by enable
        wr_status(32'h0);
        @(negedge clk);
        irq_req = 1; cur_pc = 32'h2000; #1;
        chk("R6 masked no redirect", 32'(redirect), 0);
        edge_after();
        chk("R7 pending", 32'(irq_pending), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R7 hold no redirect", 32'(redirect), 0);
            chk("R5 idle llbit", 32'(llbit_clr), 0);
            edge_after();
            chk("R7 still pending", 32'(irq_pending), 1);
        end
        @(negedge clk); irq_req = 1; edge_after();
        chk("R7 second request", 32'(irq_pending), 1);
        wr_status(32'h1);
        @(negedge clk);
        cur_pc = 32'h2000; #1;
        chk("R7 retried", 32'(redirect), 1);
        chk("R7 vector", redirect_pc, 32'h8000_0180);
        chk("R5 llbit irq", 32'(llbit_clr), 1);
        edge_after();
        chk("R7 released", 32'(irq_pending), 0);
        chk("R6 code zero", cause, 0);
        chk("R6 epc", epc, 32'h2000);
        chk("R6 status", status, 32'h3);
        @(negedge clk); #1;
        chk("R7 single delivery", 32'(redirect), 0);
        edge_after();

        // R6 immediate acceptance with delay slot
        wr_status(32'h1);
        @(negedge clk);
        irq_req = 1; cur_pc = 32'h3004; cur_in_delay = 1; #1;
        chk("R6 immediate", 32'(redirect), 1);
        edge_after();
        chk("R6 bd cause", cause, 32'h8000_0000);
        chk("R6 bd epc", epc, 32'h3000);
        chk("R6 not held", 32'(irq_pending), 0);

        // R8 collision: exception + interrupt + move-to
        wr_status(32'h1);
        @(negedge clk);
        exc_valid = 1; exc_code = 5'd12; cur_pc = 32'h4000; irq_req = 1;
        cop_valid = 1; cop_insn = enc_mt(5'd9, 5'd12); gpr_rdata = 32'hFFFF_FFFF; #1;
        chk("R8 exception vector", redirect_pc, 32'h8000_0180);
        chk("R8 no write", 32'(gpr_we), 0);
        edge_after();
        chk("R8 move flushed", status, 32'h3);
        chk("R8 cause", cause, 32'h30);
        chk("R8 epc", epc, 32'h4000);
        chk("R8 irq held", 32'(irq_pending), 1);
        @(negedge clk); #1;
        chk("R8 irq follows", 32'(redirect), 1);
        edge_after();
        chk("R3 nested irq cause", cause, 0);
        chk("R3 nested irq epc", epc, 32'h4000);
        chk("R8 irq cleared", 32'(irq_pending), 0);
        wr_status(32'h0);
        @(negedge clk);
        exc_valid = 1; exc_code = 5'd3; cur_pc = 32'h6000;
        cop_valid = 1; cop_insn = enc_mf(5'd7, 5'd12); #1;
        chk("R8 move-from flushed", 32'(gpr_we), 0);
        edge_after();

        summary();
        $finish;
    end

endmodule